// File: doc/BRIEF.md
# Floppy Status Override and Game Select Configuration Slice

This block is a small group of configuration registers that software reaches through a two-port index/data window while the chip is in configuration mode. One register keeps a read-only copy of every value written to the second UART's FIFO control register, because that register cannot be read at run time. A second register lets software force the disk-change and write-protect status of either floppy drive. A third register holds the base address and enable of a game-port chip select and drives the address decoder for it. The indices between the force register and the game register are reserved.

A two-state access machine gates the window. In `ST_LOCKED` every access is ignored and the read data is zero. The transition `GO_OPEN` is taken on the first clock edge that sees the configuration-mode input high, and it leads to `ST_OPEN`. The transition `GO_LOCKED` is taken on the first edge that sees the input low, and it clears the index register. In `ST_OPEN`, a write with the index-select input high loads the index. A write with the index-select input low goes to the register that the index names. The read data always shows the register that the index names, or shows the index itself when the index-select input is high.

The disk-change force bits can only be set by software. Hardware clears each one when a step strobe arrives while its own drive is selected. The force bits are merged per drive with the raw pins to give the status that the floppy logic sees. All strobes and selects here are active high.

Top module: `floppy_ovr_cfg`

## Requirements
- R1: After reset, index 0x16 reads 0x00, index 0x17 reads 0x03 and index 0x1E reads 0x80.
- R2: While the access machine is in `ST_LOCKED`, cfg_rdata is 0x00 and writes change neither the index nor any register. Entering `ST_OPEN` takes one clock edge with cfg_mode high, and leaving it takes one edge with cfg_mode low. The index reads back through the index port and is 0x00 after re-entry.
- R3: Each fcr_wr pulse stores fcr_wdata into the index 0x16 shadow with bits 5:4 forced to 0. Configuration writes to index 0x16 have no effect.
- R4: In index 0x17, bit 0 is the drive-0 disk-change force and bit 1 is the drive-1 disk-change force. Writing 1 to either bit sets it, and writing 0 leaves it unchanged.
- R5: A force disk-change bit clears on any edge where step_pulse and its own drive's drv_sel bit are both 1. A step pulse while only the other drive is selected leaves the bit unchanged. The clear wins over a set written in the same cycle.
- R6: In index 0x17, bit 2 is the drive-0 write-protect force and bit 3 is the drive-1 write-protect force. Both follow every write. Bits 7:4 read 0.
- R7: dskchg_out = raw_dskchg OR (drv_sel[0] AND force bit 0) OR (drv_sel[1] AND force bit 1), without a clock delay.
- R8: wrprot_out = raw_wrprot OR (drv_sel[0] AND force bit 2) OR (drv_sel[1] AND force bit 3), without a clock delay.
- R9: Indices 0x18 to 0x1D ignore writes and read 0x00.
- R10: Index 0x1E is fully writable. Its bits 7:2 are compared with address bits 9:4. game_cs is 1 when they match and bits 1:0 are not 00. A value of 00 in bits 1:0 holds game_cs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | Chip is in configuration mode |
| cfg_sel_index | input | 1 | 1 selects the index port, 0 selects the data port |
| cfg_wr | input | 1 | Write strobe for the selected port |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected port |
| fcr_wr | input | 1 | Run-time write to the UART FIFO control register |
| fcr_wdata | input | 8 | Data of that write |
| step_pulse | input | 1 | Floppy step strobe |
| drv_sel | input | 2 | Drive selects, bit n for drive n |
| raw_dskchg | input | 1 | Disk-change pin |
| raw_wrprot | input | 1 | Write-protect pin |
| dskchg_out | output | 1 | Merged disk-change status |
| wrprot_out | output | 1 | Merged write-protect status |
| io_addr_hi | input | 6 | I/O address bits 9:4 |
| game_cs | output | 1 | Game-port chip select |

## Verification
The bench writes 0 over set disk-change bits. A design that treats those bits as ordinary read/write would clear them there. It also steps one drive while the other is selected, and a design that wires the clear to the wrong select would clear the wrong bit. A set is written in the same cycle as a clear to confirm that the clear wins. Without that priority the bit would stay set after the step.

The decoder is tested at both ends of its base range and one address outside each end, and it is tested with every enable code. An off-by-one comparison would assert game_cs on a neighbouring block. Treating only one code as the enable would leave game_cs low for the other codes.

Writes are issued while locked and to the reserved and shadow indices. A design with a leaky access gate would show changed registers on the next read.

// File: rtl/fov_pkg.sv
package fov_pkg;
    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] IDX_SHADOW = 8'h16;
    localparam logic [BYTE_W-1:0] IDX_FORCE  = 8'h17;
    localparam logic [BYTE_W-1:0] IDX_RSV_LO = 8'h18;
    localparam logic [BYTE_W-1:0] IDX_RSV_HI = 8'h1D;
    localparam logic [BYTE_W-1:0] IDX_GAME   = 8'h1E;

    localparam logic [BYTE_W-1:0] FORCE_RST  = 8'h03;
    localparam logic [BYTE_W-1:0] GAME_RST   = 8'h80;
    localparam logic [BYTE_W-1:0] SHADOW_RST = 8'h00;
    localparam logic [BYTE_W-1:0] FCR_KEEP   = 8'hCF;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } port_state_e;
endpackage

// File: rtl/fov_port_fsm.sv
module fov_port_fsm
    import fov_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              cfg_sel_index,
    input  logic              cfg_wr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] index_q,
    output logic              port_open,
    output logic              data_wr
);
    port_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // transitions GO_OPEN / GO_LOCKED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (cfg_mode)  state_d = ST_OPEN;
            ST_OPEN:   if (!cfg_mode) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        port_open = 1'b0;
        unique case (state_q)
            ST_LOCKED: port_open = 1'b0;
            ST_OPEN:   port_open = 1'b1;
            default:   port_open = 1'b0;
        endcase
    end

    assign data_wr = port_open && cfg_wr && !cfg_sel_index;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               index_q <= '0;
        else if (!port_open)                      index_q <= '0;
        else if (cfg_wr && cfg_sel_index)         index_q <= cfg_wdata;
    end
endmodule

// File: rtl/fov_force_regs.sv
module fov_force_regs
    import fov_pkg::*;
#(
    parameter int unsigned NUM_DRV = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2*NUM_DRV-1:0] wr_bits,
    input  logic                 step_pulse,
    input  logic [NUM_DRV-1:0]   drv_sel,
    input  logic                 raw_dskchg,
    input  logic                 raw_wrprot,
    output logic [NUM_DRV-1:0]   force_dc,
    output logic [NUM_DRV-1:0]   force_wp,
    output logic                 dskchg_out,
    output logic                 wrprot_out
);
    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
        localparam int unsigned WP_BIT = NUM_DRV + d;

        // disk-change force: software set, step-on-own-drive clear (clear wins)
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        force_dc[d] <= FORCE_RST[d];
            else if (step_pulse && drv_sel[d]) force_dc[d] <= 1'b0;
            else if (wr_en && wr_bits[d])      force_dc[d] <= 1'b1;
        end

        // write-protect force: plain read/write
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     force_wp[d] <= FORCE_RST[WP_BIT];
            else if (wr_en) force_wp[d] <= wr_bits[WP_BIT];
        end
    end

    assign dskchg_out = raw_dskchg || (|(drv_sel & force_dc));
    assign wrprot_out = raw_wrprot || (|(drv_sel & force_wp));
endmodule

// File: rtl/fov_game_dec.sv
module fov_game_dec
    import fov_pkg::*;
#(
    parameter int unsigned HI_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [HI_W-1:0]   addr_hi,
    output logic [BYTE_W-1:0] base_q,
    output logic              game_cs
);
    localparam int unsigned EN_W = BYTE_W - HI_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     base_q <= GAME_RST;
        else if (wr_en) base_q <= wdata;
    end

    assign game_cs = (base_q[EN_W-1:0] != '0) && (addr_hi == base_q[BYTE_W-1:EN_W]);
endmodule

// File: rtl/floppy_ovr_cfg.sv
module floppy_ovr_cfg
    import fov_pkg::*;
#(
    parameter int unsigned NUM_DRV = 2,
    parameter int unsigned HI_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_mode,
    input  logic               cfg_sel_index,
    input  logic               cfg_wr,
    input  logic [BYTE_W-1:0]  cfg_wdata,
    output logic [BYTE_W-1:0]  cfg_rdata,
    input  logic               fcr_wr,
    input  logic [BYTE_W-1:0]  fcr_wdata,
    input  logic               step_pulse,
    input  logic [NUM_DRV-1:0] drv_sel,
    input  logic               raw_dskchg,
    input  logic               raw_wrprot,
    output logic               dskchg_out,
    output logic               wrprot_out,
    input  logic [HI_W-1:0]    io_addr_hi,
    output logic               game_cs
);
    localparam int unsigned FB_W = 2 * NUM_DRV;

    logic [BYTE_W-1:0]  index_q;
    logic               port_open;
    logic               data_wr;
    logic [BYTE_W-1:0]  shadow_q;
    logic [NUM_DRV-1:0] force_dc;
    logic [NUM_DRV-1:0] force_wp;
    logic [BYTE_W-1:0]  game_base;
    logic [BYTE_W-1:0]  force_view;

    fov_port_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode     (cfg_mode),
        .cfg_sel_index(cfg_sel_index),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .index_q      (index_q),
        .port_open    (port_open),
        .data_wr      (data_wr)
    );

    fov_force_regs #(.NUM_DRV(NUM_DRV)) u_force (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr && (index_q == IDX_FORCE)),
        .wr_bits   (cfg_wdata[FB_W-1:0]),
        .step_pulse(step_pulse),
        .drv_sel   (drv_sel),
        .raw_dskchg(raw_dskchg),
        .raw_wrprot(raw_wrprot),
        .force_dc  (force_dc),
        .force_wp  (force_wp),
        .dskchg_out(dskchg_out),
        .wrprot_out(wrprot_out)
    );

    fov_game_dec #(.HI_W(HI_W)) u_game (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (data_wr && (index_q == IDX_GAME)),
        .wdata  (cfg_wdata),
        .addr_hi(io_addr_hi),
        .base_q (game_base),
        .game_cs(game_cs)
    );

    // read-only copy of the UART FIFO control writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shadow_q <= SHADOW_RST;
        else if (fcr_wr) shadow_q <= fcr_wdata & FCR_KEEP;
    end

    always_comb begin
        force_view = '0;
        force_view[NUM_DRV-1:0] = force_dc;
        force_view[FB_W-1:NUM_DRV] = force_wp;
    end

    always_comb begin
        cfg_rdata = '0;
        if (port_open) begin
            if (cfg_sel_index)              cfg_rdata = index_q;
            else if (index_q == IDX_SHADOW) cfg_rdata = shadow_q;
            else if (index_q == IDX_FORCE)  cfg_rdata = force_view;
            else if (index_q == IDX_GAME)   cfg_rdata = game_base;
            else                            cfg_rdata = '0; // 0x18..0x1D and others
        end
    end
endmodule

// File: rtl/fov_chk.sv
module fov_chk
    import fov_pkg::*;
#(
    parameter int unsigned NUM_DRV = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_mode,
    input logic [BYTE_W-1:0]  cfg_rdata,
    input logic               fcr_wr,
    input logic [BYTE_W-1:0]  fcr_wdata,
    input logic [BYTE_W-1:0]  shadow_q,
    input logic               step_pulse,
    input logic [NUM_DRV-1:0] drv_sel,
    input logic [NUM_DRV-1:0] force_dc,
    input logic               raw_dskchg,
    input logic               raw_wrprot,
    input logic               dskchg_out,
    input logic               wrprot_out,
    input logic [BYTE_W-1:0]  game_base,
    input logic               game_cs
);
    assert_locked_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && $past(!cfg_mode)) |-> (cfg_rdata == '0));

    assert_shadow_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr |=> (shadow_q == ($past(fcr_wdata) & FCR_KEEP)));

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
        assert_set_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (force_dc[d] && !(step_pulse && drv_sel[d])) |=> force_dc[d]);

        assert_step_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (step_pulse && drv_sel[d]) |=> !force_dc[d]);
    end

    assert_raw_dc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        raw_dskchg |-> dskchg_out);

    assert_raw_wp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        raw_wrprot |-> wrprot_out);

    assert_cs_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (game_base[1:0] == 2'b00) |-> !game_cs);
endmodule

bind floppy_ovr_cfg fov_chk #(.NUM_DRV(NUM_DRV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cfg_rdata (cfg_rdata),
    .fcr_wr    (fcr_wr),
    .fcr_wdata (fcr_wdata),
    .shadow_q  (shadow_q),
    .step_pulse(step_pulse),
    .drv_sel   (drv_sel),
    .force_dc  (force_dc),
    .raw_dskchg(raw_dskchg),
    .raw_wrprot(raw_wrprot),
    .dskchg_out(dskchg_out),
    .wrprot_out(wrprot_out),
    .game_base (game_base),
    .game_cs   (game_cs)
);

// File: tb/sim_floppy_ovr_cfg.sv
`timescale 1ns/1ps
module sim_floppy_ovr_cfg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       cfg_sel_index = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_wdata = 8'h00;
    logic       step_pulse = 1'b0;
    logic [1:0] drv_sel = 2'b00;
    logic       raw_dskchg = 1'b0;
    logic       raw_wrprot = 1'b0;
    logic       dskchg_out;
    logic       wrprot_out;
    logic [5:0] io_addr_hi = 6'h00;
    logic       game_cs;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    floppy_ovr_cfg u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_sel_index(cfg_sel_index),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata), .step_pulse(step_pulse),
        .drv_sel(drv_sel), .raw_dskchg(raw_dskchg), .raw_wrprot(raw_wrprot),
        .dskchg_out(dskchg_out), .wrprot_out(wrprot_out),
        .io_addr_hi(io_addr_hi), .game_cs(game_cs)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk); cfg_sel_index = 1'b1; cfg_wr = 1'b1; cfg_wdata = idx;
        @(negedge clk); cfg_sel_index = 1'b0; cfg_wdata = val;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] idx, output logic [7:0] v);
        @(negedge clk); cfg_sel_index = 1'b1; cfg_wr = 1'b1; cfg_wdata = idx;
        @(negedge clk); cfg_wr = 1'b0; cfg_sel_index = 1'b0;
        #1 v = cfg_rdata;
    endtask

    task automatic step_on(input logic [1:0] sel);
        @(negedge clk); drv_sel = sel; step_pulse = 1'b1;
        @(negedge clk); drv_sel = 2'b00; step_pulse = 1'b0;
    endtask

    task automatic enter_cfg();
        @(negedge clk); cfg_mode = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        enter_cfg();
        read_reg(8'h16, v); check("R1 shadow reset", v, 8'h00);
        read_reg(8'h17, v); check("R1 force reset", v, 8'h03);
        read_reg(8'h1E, v); check("R1 game reset", v, 8'h80);
        io_addr_hi = 6'h20; #1 check("R10 cs disabled at reset", {7'b0, game_cs}, 8'h00);
    endtask

    task automatic t_locked();
        logic [7:0] v;
        write_reg(8'h1E, 8'h5A);
        @(negedge clk); cfg_sel_index = 1'b1;
        #1 check("R2 index readback", cfg_rdata, 8'h1E);
        cfg_mode = 1'b0;
        @(negedge clk); @(negedge clk);
        #1 check("R2 locked index read zero", cfg_rdata, 8'h00);
        cfg_sel_index = 1'b0;
        #1 check("R2 locked data read zero", cfg_rdata, 8'h00);
        write_reg(8'h1E, 8'h11);
        cfg_wr = 1'b1; cfg_wdata = 8'h33;
        @(negedge clk); cfg_wr = 1'b0;
        enter_cfg();
        cfg_sel_index = 1'b1;
        #1 check("R2 index cleared on entry", cfg_rdata, 8'h00);
        read_reg(8'h1E, v); check("R2 locked write ignored", v, 8'h5A);
    endtask

    task automatic t_shadow();
        logic [7:0] v;
        @(negedge clk); fcr_wr = 1'b1; fcr_wdata = 8'hFF;
        @(negedge clk); fcr_wr = 1'b0;
        read_reg(8'h16, v); check("R3 shadow FF", v, 8'hCF);
        @(negedge clk); fcr_wr = 1'b1; fcr_wdata = 8'h81;
        @(negedge clk); fcr_wr = 1'b0;
        write_reg(8'h16, 8'h00);
        read_reg(8'h16, v); check("R3 shadow read-only", v, 8'h81);
    endtask

    task automatic t_set_only();
        logic [7:0] v;
        write_reg(8'h17, 8'h00);
        read_reg(8'h17, v); check("R4 zero write keeps dc bits", v, 8'h03);
        write_reg(8'h17, 8'h0C);
        read_reg(8'h17, v); check("R6 wp set", v, 8'h0F);
        write_reg(8'h17, 8'hF0);
        read_reg(8'h17, v); check("R6 wp clear, upper zero", v, 8'h03);
    endtask

    task automatic t_step_clear();
        logic [7:0] v;
        step_on(2'b00);
        read_reg(8'h17, v); check("R5 step without select", v, 8'h03);
        step_on(2'b01);
        read_reg(8'h17, v); check("R5 drive0 clear", v, 8'h02);
        step_on(2'b10);
        read_reg(8'h17, v); check("R5 drive1 clear", v, 8'h00);
        write_reg(8'h17, 8'h02);
        read_reg(8'h17, v); check("R4 set drive1", v, 8'h02);
        // set of bit0 and clear of bit0 in same cycle: clear wins
        @(negedge clk); cfg_sel_index = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'h17;
        @(negedge clk); cfg_sel_index = 1'b0; cfg_wdata = 8'h01; step_pulse = 1'b1; drv_sel = 2'b01;
        @(negedge clk); cfg_wr = 1'b0; step_pulse = 1'b0; drv_sel = 2'b00;
        read_reg(8'h17, v); check("R5 clear beats set", v, 8'h02);
    endtask

    task automatic t_status();
        write_reg(8'h17, 8'h0F);
        @(negedge clk); drv_sel = 2'b00; raw_dskchg = 1'b0; raw_wrprot = 1'b0;
        #1 check("R7 no select", {7'b0, dskchg_out}, 8'h00);
        check("R8 no select", {7'b0, wrprot_out}, 8'h00);
        raw_dskchg = 1'b1; raw_wrprot = 1'b1;
        #1 check("R7 raw pin", {7'b0, dskchg_out}, 8'h01);
        check("R8 raw pin", {7'b0, wrprot_out}, 8'h01);
        raw_dskchg = 1'b0; raw_wrprot = 1'b0; drv_sel = 2'b01;
        #1 check("R7 drive0 forced", {7'b0, dskchg_out}, 8'h01);
        check("R8 drive0 forced", {7'b0, wrprot_out}, 8'h01);
        drv_sel = 2'b00;
        write_reg(8'h17, 8'h04);
        @(negedge clk); drv_sel = 2'b10;
        #1 check("R7 drive1 forced", {7'b0, dskchg_out}, 8'h01);
        check("R8 drive1 not forced", {7'b0, wrprot_out}, 8'h00);
        step_on(2'b10);
        @(negedge clk); drv_sel = 2'b10;
        #1 check("R7 drive1 after step", {7'b0, dskchg_out}, 8'h00);
        drv_sel = 2'b01;
        #1 check("R7 drive0 still forced", {7'b0, dskchg_out}, 8'h01);
        check("R8 drive0 wp", {7'b0, wrprot_out}, 8'h01);
        @(negedge clk); drv_sel = 2'b00;
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        for (int i = 8'h18; i <= 8'h1D; i++) begin
            write_reg(8'(i), 8'hFF);
            read_reg(8'(i), v); check("R9 reserved reads zero", v, 8'h00);
        end
        read_reg(8'h17, v); check("R9 force reg untouched", v, 8'h05);
    endtask

    task automatic t_game();
        logic [7:0] v;
        write_reg(8'h1E, 8'h41); // base 0x100, enable 01
        @(negedge clk);
        io_addr_hi = 6'h10; #1 check("R10 low edge hit", {7'b0, game_cs}, 8'h01);
        io_addr_hi = 6'h0F; #1 check("R10 below low edge", {7'b0, game_cs}, 8'h00);
        io_addr_hi = 6'h11; #1 check("R10 above block", {7'b0, game_cs}, 8'h00);
        write_reg(8'h1E, 8'hFF); // base 0x3F0, enable 11
        io_addr_hi = 6'h3F; #1 check("R10 high edge hit", {7'b0, game_cs}, 8'h01);
        io_addr_hi = 6'h3E; #1 check("R10 below high edge", {7'b0, game_cs}, 8'h00);
        write_reg(8'h1E, 8'hFE); // enable 10
        io_addr_hi = 6'h3F; #1 check("R10 enable code 10", {7'b0, game_cs}, 8'h01);
        write_reg(8'h1E, 8'hFC); // enable 00
        #1 check("R10 disabled", {7'b0, game_cs}, 8'h00);
        read_reg(8'h1E, v); check("R10 readback", v, 8'hFC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked();
        t_shadow();
        t_set_only();
        t_step_clear();
        t_status();
        t_reserved();
        t_game();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule